// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block is the receive half of a descriptor-driven DMA for a network controller. It walks a ring of receive descriptors. The ring sits in a small internal descriptor store that a host port can read and write. The engine takes frame bytes from a receive FIFO and writes them into the buffers those descriptors name, through a plain byte-wide buffer-memory write port. A frame longer than one buffer spreads across consecutive descriptors. Each descriptor is handed back to the host once its buffer is full or the frame has ended.

The engine has two operating conditions. In RUN it fetches, fills and closes descriptors. When it fetches a descriptor that the host still owns, it enters SUSPEND and keeps its ring position. While suspended, a newly arrived frame or a poll demand makes it refetch the same descriptor. If the host has handed that descriptor over, reception resumes. If the host still holds it, a flush-disable input selects what happens to the frame at the head of the FIFO. With flushing allowed, that frame and every other queued frame is discarded and counted. With flushing disabled, the frame stays in the FIFO and the engine stays suspended.

Top module: `rxring_dma`

## Requirements
- R1: The engine writes buffer memory only through a descriptor whose word 0 bit 31 (ownership) is 1. A descriptor with that bit at 0 never receives data.
- R2: When a segment is closed, word 0 bit 9 is 1 if the segment holds the first byte of the frame, and bit 8 is 1 if it holds the last byte. A frame that fits in one buffer sets both bits in the same descriptor.
- R3: Closing a segment rewrites its word 0 with bit 31 cleared. On the segment holding the frame end, bits 29:16 carry the frame length in bytes and a one-cycle `sts_done` pulse is given; on other segments bits 29:16 are 0.
- R4: Word 1 of a descriptor holds the buffer base address in bits 15:0, the buffer size in bytes in bits 27:16 and an end-of-ring flag in bit 31. After a descriptor with that flag set, the next fetch is at descriptor 0; otherwise it is at the next index.
- R5: Fetching a host-owned descriptor in RUN gives a one-cycle `sts_unavail` pulse and enters SUSPEND. The ring position is kept, so the next frame received lands in that same descriptor once the host hands it over.
- R6: In SUSPEND, a `poll` pulse or an `rx_arrive` pulse refetches the current descriptor. If it is now DMA-owned, the engine resumes and receives the queued frame into it.
- R7: With `flush_dis` low, a refetch that finds the descriptor still host-owned discards the head frame from the FIFO without writing buffer memory. It adds one to the missed-frame counter, repeats this for every further queued frame, and gives no `sts_unavail` pulse.
- R8: With `flush_dis` high, such a refetch leaves the frame in the FIFO, gives a new `sts_unavail` pulse and stays in SUSPEND.
- R9: The missed-frame counter (width `MISS_W`, 16 by default) stops at its all-ones value.
- R10: A host read at address 2·`NUM_DESC` returns the missed-frame counter one cycle later and clears it. A discard completing in the same cycle as the read leaves the counter at 1, so no count is lost. Addresses below that read and write descriptor words: index = address/2, with address bit 0 selecting word 1.
- R11: The bytes of a segment are written to consecutive buffer addresses starting at the descriptor's base address, in arrival order.
- R12: While `start` is low after reset, no byte is taken from the receive FIFO. Raising `start` fetches descriptor 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Receive enable; rising into RUN triggers a fetch |
| flush_dis | input | 1 | 1 holds frames while suspended, 0 discards them |
| poll | input | 1 | Receive poll demand pulse |
| hp_wr | input | 1 | Host write strobe |
| hp_rd | input | 1 | Host read strobe |
| hp_addr | input | IDX_W+2 | Host word address |
| hp_wdata | input | 32 | Host write data |
| hp_rdata | output | 32 | Host read data, valid the cycle after hp_rd |
| rx_valid | input | 1 | FIFO head byte present |
| rx_data | input | DATA_W | FIFO head byte |
| rx_last | input | 1 | FIFO head byte ends its frame |
| rx_arrive | input | 1 | Pulse: a new frame entered the FIFO |
| rx_ready | output | 1 | Pop of the FIFO head this cycle |
| buf_we | output | 1 | Buffer memory write strobe |
| buf_addr | output | BUF_AW | Buffer memory byte address |
| buf_wdata | output | DATA_W | Buffer memory write data |
| sts_done | output | 1 | Pulse: frame fully written and closed |
| sts_unavail | output | 1 | Pulse: host-owned descriptor met |

## Verification
Two events can meet in one cycle: a queued frame's discard completes, and the host reads the missed-frame counter, which clears it. The bench floods a suspended engine with one-byte frames and reads the counter on every cycle of the flood, so some reads are bound to land on a discard. It judges the result by adding every value read to a final read; the sum must equal the number of frames pushed, and a lost or doubled count shows up in that total.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
   // descriptor word 0
   localparam int OWN_BIT   = 31;
   localparam int LEN_LSB   = 16;
   localparam int LEN_W     = 14;
   localparam int FIRST_BIT = 9;
   localparam int LAST_BIT  = 8;
   // descriptor word 1
   localparam int EOR_BIT   = 31;
   localparam int SIZE_LSB  = 16;
   localparam int SIZE_W    = 12;
   localparam int BASE_W    = 16;

   typedef enum logic [2:0] {
      ST_STOP, ST_FETCH, ST_IDLE, ST_XFER, ST_CLOSE, ST_SUSP, ST_DROP
   } rx_state_e;
endpackage

// File: rtl/rxring_miss_ctr.sv
module rxring_miss_ctr #(
   parameter int W        = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         clr_rd,
   output logic [W-1:0] count
);
   logic [W-1:0] q;
   logic [W-1:0] q_inc;

   generate
      if (SATURATE) begin : g_sat
         assign q_inc = (&q) ? q : q + 1'b1;
      end else begin : g_wrap
         assign q_inc = q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (clr_rd) q <= inc ? W'(1) : '0;
      else if (inc)    q <= q_inc;
   end

   assign count = q;
endmodule

// File: rtl/rxring_desc_store.sv
module rxring_desc_store
   import rxring_pkg::*;
#(
   parameter int NUM_DESC = 4,
   parameter int BUF_AW   = 16,
   localparam int IDX_W   = $clog2(NUM_DESC)
) (
   input  logic              clk,
   input  logic              rst_n,
   // host side
   input  logic              host_we,
   input  logic [IDX_W-1:0]  host_idx,
   input  logic              host_word,
   input  logic [31:0]       host_wdata,
   output logic [31:0]       host_rdata,
   // engine side
   input  logic [IDX_W-1:0]  eng_idx,
   output logic              eng_own,
   output logic [BUF_AW-1:0] eng_base,
   output logic [SIZE_W-1:0] eng_size,
   output logic              eng_eor,
   input  logic              eng_we,
   input  logic [31:0]       eng_wdata
);
   logic [31:0] w0_q [NUM_DESC];
   logic [31:0] w1_q [NUM_DESC];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int d = 0; d < NUM_DESC; d++) begin
            w0_q[d] <= '0;
            w1_q[d] <= '0;
         end
      end else begin
         for (int d = 0; d < NUM_DESC; d++) begin
            // engine close has priority over a host write to word 0
            if (eng_we && eng_idx == IDX_W'(d))
               w0_q[d] <= eng_wdata;
            else if (host_we && !host_word && host_idx == IDX_W'(d))
               w0_q[d] <= host_wdata;
            if (host_we && host_word && host_idx == IDX_W'(d))
               w1_q[d] <= host_wdata;
         end
      end
   end

   assign host_rdata = host_word ? w1_q[host_idx] : w0_q[host_idx];
   assign eng_own    = w0_q[eng_idx][OWN_BIT];
   assign eng_base   = w1_q[eng_idx][BUF_AW-1:0];
   assign eng_size   = w1_q[eng_idx][SIZE_LSB +: SIZE_W];
   assign eng_eor    = w1_q[eng_idx][EOR_BIT];
endmodule

// File: rtl/rxring_fsm.sv
module rxring_fsm
   import rxring_pkg::*;
#(
   parameter int IDX_W  = 2,
   parameter int BUF_AW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              flush_dis,
   input  logic              poll,
   input  logic              rx_valid,
   input  logic              rx_last,
   input  logic              rx_arrive,
   output logic              rx_ready,
   output logic [IDX_W-1:0]  cur_idx,
   input  logic              d_own,
   input  logic [BUF_AW-1:0] d_base,
   input  logic [SIZE_W-1:0] d_size,
   input  logic              d_eor,
   output logic              dw_we,
   output logic [31:0]       dw_data,
   output logic              buf_we,
   output logic [BUF_AW-1:0] buf_addr,
   output logic              sts_done,
   output logic              sts_unavail,
   output logic              miss_inc,
   output logic              dropping,
   output logic              suspended
);
   rx_state_e         state;
   logic [IDX_W-1:0]  cur;
   logic [BUF_AW-1:0] base;
   logic [SIZE_W-1:0] size, cnt;
   logic [LEN_W-1:0]  flen;
   logic              eor, seg_first, last_seg, mid, requeue, from_susp;
   logic              pop, drop_go, wake;

   assign rx_ready    = (state == ST_XFER) || (state == ST_DROP);
   assign pop         = rx_ready && rx_valid;
   assign buf_we      = (state == ST_XFER) && rx_valid;
   assign buf_addr    = base + BUF_AW'(cnt);
   assign cur_idx     = cur;
   assign dw_we       = (state == ST_CLOSE);
   assign drop_go     = (state == ST_FETCH) && !d_own && from_susp && !mid
                        && !flush_dis && rx_valid;
   assign sts_unavail = (state == ST_FETCH) && !d_own && !drop_go;
   assign sts_done    = (state == ST_CLOSE) && last_seg;
   assign miss_inc    = (state == ST_DROP) && rx_valid && rx_last;
   assign dropping    = (state == ST_DROP);
   assign suspended   = (state == ST_SUSP);
   assign wake        = rx_arrive || poll || (requeue && rx_valid);

   always_comb begin
      dw_data            = '0;
      dw_data[FIRST_BIT] = seg_first;
      dw_data[LAST_BIT]  = last_seg;
      if (last_seg) dw_data[LEN_LSB +: LEN_W] = flen;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_STOP;
         cur       <= '0;
         base      <= '0;
         size      <= '0;
         cnt       <= '0;
         flen      <= '0;
         eor       <= 1'b0;
         seg_first <= 1'b0;
         last_seg  <= 1'b0;
         mid       <= 1'b0;
         requeue   <= 1'b0;
         from_susp <= 1'b0;
      end else begin
         unique case (state)
            ST_STOP: if (start) begin
               state     <= ST_FETCH;
               from_susp <= 1'b0;
            end
            ST_FETCH: begin
               requeue <= 1'b0;
               if (d_own) begin
                  base  <= d_base;
                  size  <= d_size;
                  eor   <= d_eor;
                  cnt   <= '0;
                  state <= mid ? ST_XFER : ST_IDLE;
               end else if (drop_go) begin
                  state <= ST_DROP;
               end else begin
                  state <= ST_SUSP;
               end
            end
            ST_IDLE: begin
               if (!start) state <= ST_STOP;
               else if (rx_valid) begin
                  state     <= ST_XFER;
                  flen      <= '0;
                  seg_first <= 1'b1;
               end
            end
            ST_XFER: if (pop) begin
               cnt  <= cnt + 1'b1;
               flen <= flen + 1'b1;
               if (rx_last) begin
                  last_seg <= 1'b1;
                  state    <= ST_CLOSE;
               end else if (cnt + 1'b1 == size) begin
                  last_seg <= 1'b0;
                  state    <= ST_CLOSE;
               end
            end
            ST_CLOSE: begin
               cur       <= eor ? '0 : cur + 1'b1;
               mid       <= !last_seg;
               seg_first <= 1'b0;
               from_susp <= 1'b0;
               state     <= ST_FETCH;
            end
            ST_SUSP: begin
               if (wake) begin
                  state     <= ST_FETCH;
                  from_susp <= 1'b1;
               end else if (!start && !mid) begin
                  state <= ST_STOP;
               end
            end
            ST_DROP: if (pop && rx_last) begin
               requeue <= 1'b1;
               state   <= ST_SUSP;
            end
            default: state <= ST_STOP;
         endcase
      end
   end
endmodule

// File: rtl/rxring_dma.sv
module rxring_dma
   import rxring_pkg::*;
#(
   parameter int NUM_DESC = 4,
   parameter int BUF_AW   = 16,
   parameter int DATA_W   = 8,
   parameter int MISS_W   = 16,
   parameter bit MISS_SAT = 1'b1,
   localparam int IDX_W   = $clog2(NUM_DESC),
   localparam int HA_W    = IDX_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              flush_dis,
   input  logic              poll,
   input  logic              hp_wr,
   input  logic              hp_rd,
   input  logic [HA_W-1:0]   hp_addr,
   input  logic [31:0]       hp_wdata,
   output logic [31:0]       hp_rdata,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_last,
   input  logic              rx_arrive,
   output logic              rx_ready,
   output logic              buf_we,
   output logic [BUF_AW-1:0] buf_addr,
   output logic [DATA_W-1:0] buf_wdata,
   output logic              sts_done,
   output logic              sts_unavail
);
   initial begin
      assert (NUM_DESC >= 2 && (1 << IDX_W) == NUM_DESC)
         else $error("NUM_DESC must be a power of two of at least 2");
      assert (BUF_AW >= 1 && BUF_AW <= BASE_W)
         else $error("BUF_AW must fit the word 1 base field");
      assert (MISS_W >= 1 && MISS_W <= 32)
         else $error("MISS_W must be 1..32");
   end

   logic              ctr_sel, cnt_rd;
   logic [IDX_W-1:0]  host_idx, cur_idx;
   logic [31:0]       host_word_data, dw_data;
   logic              d_own, d_eor, dw_we, miss_inc, drop_act, in_susp;
   logic [BUF_AW-1:0] d_base;
   logic [SIZE_W-1:0] d_size;
   logic [MISS_W-1:0] miss_cnt;
   logic [31:0]       rdata_q;

   assign ctr_sel   = hp_addr[HA_W-1];
   assign host_idx  = hp_addr[IDX_W:1];
   assign cnt_rd    = hp_rd && ctr_sel;
   assign buf_wdata = rx_data;

   rxring_desc_store #(.NUM_DESC(NUM_DESC), .BUF_AW(BUF_AW)) u_store (
      .clk, .rst_n,
      .host_we   (hp_wr && !ctr_sel),
      .host_idx  (host_idx),
      .host_word (hp_addr[0]),
      .host_wdata(hp_wdata),
      .host_rdata(host_word_data),
      .eng_idx   (cur_idx),
      .eng_own   (d_own),
      .eng_base  (d_base),
      .eng_size  (d_size),
      .eng_eor   (d_eor),
      .eng_we    (dw_we),
      .eng_wdata (dw_data)
   );

   rxring_fsm #(.IDX_W(IDX_W), .BUF_AW(BUF_AW)) u_fsm (
      .clk, .rst_n, .start, .flush_dis, .poll,
      .rx_valid, .rx_last, .rx_arrive, .rx_ready,
      .cur_idx, .d_own, .d_base, .d_size, .d_eor,
      .dw_we, .dw_data, .buf_we, .buf_addr,
      .sts_done, .sts_unavail,
      .miss_inc, .dropping(drop_act), .suspended(in_susp)
   );

   rxring_miss_ctr #(.W(MISS_W), .SATURATE(MISS_SAT)) u_miss (
      .clk, .rst_n, .inc(miss_inc), .clr_rd(cnt_rd), .count(miss_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata_q <= '0;
      else if (hp_rd) rdata_q <= ctr_sel ? 32'(miss_cnt) : host_word_data;
   end
   assign hp_rdata = rdata_q;
endmodule

// File: rtl/rxring_chk.sv
module rxring_chk #(
   parameter int BUF_AW = 16,
   parameter int MISS_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              buf_we,
   input logic [BUF_AW-1:0] buf_addr,
   input logic              rx_ready,
   input logic              rx_valid,
   input logic              sts_unavail,
   input logic              dropping,
   input logic              suspended,
   input logic [MISS_W-1:0] miss,
   input logic              cnt_rd
);
   // R11: a buffer write always consumes the FIFO head
   p_we_pops_r11: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |-> (rx_ready && rx_valid));

   // R11: back-to-back writes within a segment step the address by one
   p_addr_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_we && $past(buf_we)) |-> (buf_addr == BUF_AW'($past(buf_addr) + 1'b1)));

   // R7 / R1: a discarded frame never reaches buffer memory
   p_drop_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dropping |-> !buf_we);

   // R5: meeting a host-owned descriptor leads into suspend
   p_unavail_suspends_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sts_unavail |=> suspended);

   // R9: a full counter stays full unless read
   p_miss_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_rd && (&miss)) |=> (&miss));

   // R10: a read leaves at most the coincident increment
   p_read_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_rd |=> (miss <= MISS_W'(1)));
endmodule

bind rxring_dma rxring_chk #(.BUF_AW(BUF_AW), .MISS_W(MISS_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .buf_we     (buf_we),
   .buf_addr   (buf_addr),
   .rx_ready   (rx_ready),
   .rx_valid   (rx_valid),
   .sts_unavail(sts_unavail),
   .dropping   (drop_act),
   .suspended  (in_susp),
   .miss       (miss_cnt),
   .cnt_rd     (cnt_rd)
);

// File: tb/sim_rxring_dma.sv
module sim_rxring_dma;
   localparam int CTR_ADDR = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, flush_dis = 1'b0, poll = 1'b0;
   logic        hp_wr = 1'b0, hp_rd = 1'b0;
   logic [3:0]  hp_addr = '0;
   logic [31:0] hp_wdata = '0;
   logic [31:0] hp_rdata;
   logic        rx_valid, rx_last, rx_ready, rx_arrive = 1'b0;
   logic [7:0]  rx_data;
   logic        buf_we, sts_done, sts_unavail;
   logic [15:0] buf_addr;
   logic [7:0]  buf_wdata;

   logic [7:0]  fifo_d [256];
   logic        fifo_l [256];
   logic [7:0]  wr_ptr = '0;
   logic [7:0]  rd_ptr = '0;
   logic [7:0]  bmem [256];
   int          done_cnt = 0, ua_cnt = 0;
   int          checks = 0, errs = 0;

   always #10 clk = ~clk;

   assign rx_valid = (wr_ptr != rd_ptr);
   assign rx_data  = fifo_d[rd_ptr];
   assign rx_last  = fifo_l[rd_ptr];

   rxring_dma #(.NUM_DESC(4), .MISS_W(4)) u0 (
      .clk, .rst_n, .start, .flush_dis, .poll,
      .hp_wr, .hp_rd, .hp_addr, .hp_wdata, .hp_rdata,
      .rx_valid, .rx_data, .rx_last, .rx_arrive, .rx_ready,
      .buf_we, .buf_addr, .buf_wdata, .sts_done, .sts_unavail
   );

   always @(posedge clk) begin
      if (rx_ready && rx_valid) rd_ptr <= rd_ptr + 1'b1;
      if (buf_we) bmem[buf_addr[7:0]] <= buf_wdata;
      if (sts_done) done_cnt <= done_cnt + 1;
      if (sts_unavail) ua_cnt <= ua_cnt + 1;
   end

   // frame table: length, first descriptor, segment count (buffers are 8 bytes)
   localparam int VEC_N = 4;
   localparam int VEC_LEN  [VEC_N] = '{3, 8, 11, 5};
   localparam int VEC_DESC [VEC_N] = '{0, 1, 2, 0};
   localparam int VEC_NSEG [VEC_N] = '{1, 1, 2, 1};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic host_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      hp_wr = 1'b1; hp_addr = a; hp_wdata = d;
      @(negedge clk);
      hp_wr = 1'b0;
   endtask

   task automatic host_read(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      hp_rd = 1'b1; hp_addr = a;
      @(negedge clk);
      hp_rd = 1'b0;
      d = hp_rdata;
   endtask

   task automatic push_frame(input int len, input int seed, input bit announce);
      for (int b = 0; b < len; b++) begin
         fifo_d[wr_ptr] = 8'(seed + b);
         fifo_l[wr_ptr] = (b == len - 1);
         wr_ptr = wr_ptr + 1'b1;
      end
      if (announce) begin
         rx_arrive = 1'b1;
         @(negedge clk);
         rx_arrive = 1'b0;
      end
   endtask

   task automatic wait_done(input int n, input string req);
      int t;
      t = 0;
      while (done_cnt < n && t < 300) begin
         @(negedge clk);
         t++;
      end
      chk(req, done_cnt, n);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errs++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      int          sum;
      for (int i = 0; i < 256; i++) bmem[i] = 8'hEE;
      idle(3);
      // reset state
      chk("R12 reset rx_ready", {31'b0, rx_ready}, 32'd0);
      chk("R11 reset buf_we", {31'b0, buf_we}, 32'd0);
      chk("R3 reset sts_done", {31'b0, sts_done}, 32'd0);
      rst_n = 1'b1;
      idle(1);
      host_read(4'(CTR_ADDR), rd);
      chk("R10 counter after reset", rd, 32'd0);

      // ring: 4 descriptors, 8-byte buffers at 16*i, end-of-ring on the last
      for (int i = 0; i < 4; i++) begin
         host_write(4'(2*i+1), ((i == 3) ? 32'h8000_0000 : 32'h0) | (32'd8 << 16) | 32'(16*i));
         host_write(4'(2*i), 32'h8000_0000);
      end

      // R12: frame queued while stopped stays in the FIFO
      push_frame(VEC_LEN[0], 0, 1'b1);
      idle(10);
      chk("R12 no pop while stopped", 32'(wr_ptr - rd_ptr), 32'(VEC_LEN[0]));
      start = 1'b1;

      for (int k = 0; k < VEC_N; k++) begin
         if (k > 0) push_frame(VEC_LEN[k], 32*k, 1'b1);
         wait_done(k + 1, "R3 done pulse per frame");
         for (int s = 0; s < VEC_NSEG[k]; s++) begin
            int  d, lo, hi;
            bit  lastb;
            d     = (VEC_DESC[k] + s) % 4;   // R4 wrap after descriptor 3
            lastb = (s == VEC_NSEG[k] - 1);
            lo    = s * 8;
            hi    = (VEC_LEN[k] < lo + 8) ? VEC_LEN[k] : lo + 8;
            host_read(4'(2*d), rd);
            chk("R2/R3/R4 closed word0", rd,
                (lastb ? (32'(VEC_LEN[k]) << 16) : 32'd0) |
                ((s == 0) ? 32'h200 : 32'h0) | (lastb ? 32'h100 : 32'h0));
            for (int b = lo; b < hi; b++)
               chk("R11 buffer byte", {24'b0, bmem[8'(16*d + b - lo)]}, 32'(8'(32*k + b)));
            host_write(4'(2*d), 32'h8000_0000);
         end
      end

      // R5: descriptor 2 host-owned; frame lands in descriptor 1, then suspend
      host_write(4'd4, 32'h0);
      push_frame(4, 8'h80, 1'b1);
      wait_done(5, "R3 frame into descriptor 1");
      idle(4);
      chk("R5 unavailable pulse", 32'(ua_cnt), 32'd1);
      host_read(4'd2, rd);
      chk("R2 single-buffer frame flags", rd, (32'd4 << 16) | 32'h300);

      // R7: flushing allowed, one frame then two queued frames
      push_frame(5, 8'hA0, 1'b1);
      idle(20);
      chk("R7 frame discarded", 32'(wr_ptr - rd_ptr), 32'd0);
      chk("R7 no done pulse", 32'(done_cnt), 32'd5);
      chk("R7 no unavailable pulse", 32'(ua_cnt), 32'd1);
      chk("R1 host-owned buffer untouched", {24'b0, bmem[32]}, 32'h40);
      host_read(4'(CTR_ADDR), rd);
      chk("R7 missed count", rd, 32'd1);
      host_read(4'(CTR_ADDR), rd);
      chk("R10 cleared by read", rd, 32'd0);
      push_frame(2, 8'hB0, 1'b1);
      push_frame(3, 8'hB8, 1'b1);
      idle(30);
      chk("R7 queued frames discarded", 32'(wr_ptr - rd_ptr), 32'd0);
      host_read(4'(CTR_ADDR), rd);
      chk("R7 each queued frame counted", rd, 32'd2);

      // R8: flushing disabled holds the frame
      flush_dis = 1'b1;
      push_frame(3, 8'hC0, 1'b1);
      idle(10);
      chk("R8 unavailable again", 32'(ua_cnt), 32'd2);
      chk("R8 frame held in FIFO", 32'(wr_ptr - rd_ptr), 32'd3);
      host_read(4'(CTR_ADDR), rd);
      chk("R8 nothing counted", rd, 32'd0);
      chk("R1 no write while held", {24'b0, bmem[32]}, 32'h40);

      // R6: hand descriptor 2 over and poll; position retained (R5)
      host_write(4'd4, 32'h8000_0000);
      @(negedge clk); poll = 1'b1;
      @(negedge clk); poll = 1'b0;
      wait_done(6, "R6 resumed after poll");
      host_read(4'd4, rd);
      chk("R5 retained position word0", rd, (32'd3 << 16) | 32'h300);
      chk("R6 data in retained buffer", {24'b0, bmem[32]}, 32'hC0);
      chk("R6 no extra unavailable", 32'(ua_cnt), 32'd2);

      // R9: suspend at descriptor 0, then flood with flushing allowed
      flush_dis = 1'b0;
      host_write(4'd0, 32'h0);
      push_frame(2, 8'hD0, 1'b1);
      wait_done(7, "R3 frame into descriptor 3");
      idle(4);
      chk("R5 suspend at descriptor 0", 32'(ua_cnt), 32'd3);
      for (int f = 0; f < 18; f++) push_frame(1, f, 1'b1);
      idle(120);
      chk("R7 flood drained", 32'(wr_ptr - rd_ptr), 32'd0);
      host_read(4'(CTR_ADDR), rd);
      chk("R9 saturated count", rd, 32'd15);

      // R10: read on every cycle while discards complete
      sum = 0;
      fork
         begin
            for (int f = 0; f < 10; f++) push_frame(1, 8'hE0 + f, 1'b1);
         end
         begin
            @(negedge clk);
            hp_addr = 4'(CTR_ADDR);
            hp_rd = 1'b1;
            for (int c = 0; c < 80; c++) begin
               @(negedge clk);
               sum += int'(hp_rdata);
            end
            hp_rd = 1'b0;
         end
      join
      idle(10);
      host_read(4'(CTR_ADDR), rd);
      sum += int'(rd);
      chk("R10 no count lost on coincident read", 32'(sum), 32'd10);
      chk("R7 coincident flood drained", 32'(wr_ptr - rd_ptr), 32'd0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
   end
endmodule